// File: doc/BRIEF.md
# Ingress Priority-Group Admission and Pause Controller

This block does buffer admission for one ingress port. It keeps cell counts for eight priority groups and decides where each arriving packet goes. A packet can be placed in the group's guaranteed minimum, in a shared service pool, or in per-group headroom, or it can be dropped. Groups 0 to 5 are lossless-capable. When such a group can no longer fit a packet in its shared allowance, the block raises a flow-control stop for every priority mapped to that group. Cells that are still arriving then land in headroom. Groups 6 and 7 are lossy: they use only the lossy shared pool, drop at their limit and never pause.

The shared allowance is a dynamic threshold. It is the free space of the service pool scaled by a logarithmic alpha code, so groups that compete for the pool settle on fair shares. Releases hand cells back in the reverse order of filling. The stop lifts only after a release has brought the group's shared usage a programmable margin below the current threshold. Headroom drops and lossy drops are counted in saturating counters. The block does not build the pause frames that go on the wire.

Top module: `pgc_ingress`

## Requirements
- R1: After reset, no decision is valid, the pause vector is zero, both drop counters are zero and every group holds zero cells.
- R2: A lossless group that is not paused first fills its minimum up to `cfg_min_i`. Region code 1 (minimum) is reported when the whole packet fits there. Region code 2 (shared) is reported when the remainder also fits in shared space.
- R3: The shared limit is F·2^(k−7), where F is the service pool's free space (size minus used) and k is the pool's alpha code (0..10; larger codes are treated as 10). A remainder is accepted only if the group's shared usage plus the remainder is no more than that limit, and the remainder is no more than F.
- R4: When a lossless group's remainder fails the shared test, the group becomes paused. The remainder goes to headroom, and the minimum part is kept, with region code 3. While the group stays paused, every later arrival to it goes to headroom as a whole.
- R5: A headroom placement that would take the group above `cfg_hdrm_i`, or the headroom pool above `cfg_hdrm_pool_i`, drops the whole packet. The block then reports region code 0 and increments the resource-error counter.
- R6: Groups 6 and 7 place the whole packet in the lossy pool under its own alpha. If the packet does not fit, it is dropped with region code 0 and the lossy-drop counter increments. These groups never use minimum or headroom space and never pause.
- R7: Pause bit p is 1 exactly when `cfg_pfc_en_i[p]` is set and the group in field p of `cfg_pri_pg_i` (3 bits at position 3p) is paused.
- R8: A release takes cells from headroom first, then from shared, then from minimum, each clamped to what the group holds.
- R9: A paused group returns to running only in a cycle with a release to that group, and only if its shared usage after the release plus `cfg_hyst_i` is below the lossless limit computed after the release.
- R10: The decision shows up one clock after the arrival. `dec_valid_o` is low in cycles after an idle arrival input. Both counters saturate at all ones.
- R11: A release and an arrival in the same cycle are handled with the release first. The arrival is judged on the state after the release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| arr_valid_i | input | 1 | Packet arrival strobe |
| arr_pg_i | input | 3 | Priority group of the arrival |
| arr_cells_i | input | 6 | Cells in the arriving packet |
| rel_valid_i | input | 1 | Release strobe |
| rel_pg_i | input | 3 | Priority group being released |
| rel_cells_i | input | 14 | Cells released |
| cfg_pfc_en_i | input | 8 | Flow control enabled, per priority |
| cfg_pri_pg_i | input | 24 | Priority-to-group map, 3 bits per priority |
| cfg_min_i | input | 14 | Minimum cells per lossless group |
| cfg_hdrm_i | input | 14 | Headroom cells per lossless group |
| cfg_hyst_i | input | 14 | Resume margin in cells |
| cfg_ll_alpha_i | input | 4 | Lossless pool alpha code |
| cfg_ly_alpha_i | input | 4 | Lossy pool alpha code |
| cfg_ll_pool_i | input | 14 | Lossless shared pool size |
| cfg_ly_pool_i | input | 14 | Lossy shared pool size |
| cfg_hdrm_pool_i | input | 14 | Headroom pool size |
| dec_valid_o | output | 1 | Decision valid |
| dec_region_o | output | 2 | 0 drop, 1 minimum, 2 shared, 3 headroom |
| pause_o | output | 8 | Per-priority stop vector |
| res_err_cnt_o | output | 16 | Headroom-overflow drop count |
| lossy_drop_cnt_o | output | 16 | Lossy-limit drop count |

## Verification
The assertions check, on every cycle, how events are ordered. A decision always follows an arrival. A rising pause bit coincides with a headroom or drop decision. A falling pause bit follows a release. Lossy groups never report minimum or headroom. Each counter moves only alongside a drop of its own kind. Headroom pool use stays within its size. Only the bench's scenarios can show the arithmetic: where the alpha-scaled limit falls for each code, how a packet splits between minimum and shared, which release order is used, the resume margin, what happens when a release and an arrival come together, and that the counters saturate. To show these, the bench sweeps every alpha code and compares each result with an arithmetic model.

// File: rtl/pgc_pkg.sv
package pgc_pkg;
  typedef enum logic [1:0] {
    REG_DROP = 2'd0,
    REG_MIN  = 2'd1,
    REG_SHR  = 2'd2,
    REG_HDRM = 2'd3
  } region_e;

  localparam int ALPHA_W     = 4;
  localparam int ALPHA_UNITY = 7;
  localparam int ALPHA_TOP   = 10;
  localparam int NUM_POOLS   = 2;
endpackage

// File: rtl/pgc_thresh.sv
module pgc_thresh
  import pgc_pkg::*;
#(
  parameter int CELL_W = 14
) (
  input  logic [CELL_W-1:0]  pool_size_i,
  input  logic [CELL_W-1:0]  pool_used_i,
  input  logic [ALPHA_W-1:0] alpha_i,
  output logic [CELL_W-1:0]  free_o,
  output logic [CELL_W+3:0]  limit_o
);
  logic [ALPHA_W-1:0] code;
  logic [CELL_W+3:0]  wide;

  always_comb begin
    free_o = (pool_size_i > pool_used_i) ? (pool_size_i - pool_used_i) : '0;
    code   = (alpha_i > ALPHA_W'(ALPHA_TOP)) ? ALPHA_W'(ALPHA_TOP) : alpha_i;
    wide   = {4'b0000, free_o};
    if (code >= ALPHA_W'(ALPHA_UNITY)) begin
      limit_o = wide << (code - ALPHA_W'(ALPHA_UNITY));
    end else begin
      limit_o = wide >> (ALPHA_W'(ALPHA_UNITY) - code);
    end
  end
endmodule

// File: rtl/pgc_release.sv
module pgc_release #(
  parameter int CELL_W = 14
) (
  input  logic [CELL_W-1:0] cells_i,
  input  logic [CELL_W-1:0] hdrm_i,
  input  logic [CELL_W-1:0] shr_i,
  input  logic [CELL_W-1:0] min_i,
  output logic [CELL_W-1:0] sub_hdrm_o,
  output logic [CELL_W-1:0] sub_shr_o,
  output logic [CELL_W-1:0] sub_min_o
);
  logic [CELL_W-1:0] left1;
  logic [CELL_W-1:0] left2;

  always_comb begin
    sub_hdrm_o = (cells_i < hdrm_i) ? cells_i : hdrm_i;
    left1      = cells_i - sub_hdrm_o;
    sub_shr_o  = (left1 < shr_i) ? left1 : shr_i;
    left2      = left1 - sub_shr_o;
    sub_min_o  = (left2 < min_i) ? left2 : min_i;
  end
endmodule

// File: rtl/pgc_admit.sv
module pgc_admit
  import pgc_pkg::*;
#(
  parameter int CELL_W = 14,
  parameter int PKT_W  = 6
) (
  input  logic              valid_i,
  input  logic              lossless_i,
  input  logic              paused_i,
  input  logic [PKT_W-1:0]  cells_i,
  input  logic [CELL_W-1:0] min_used_i,
  input  logic [CELL_W-1:0] shr_used_i,
  input  logic [CELL_W-1:0] hdrm_used_i,
  input  logic [CELL_W-1:0] cfg_min_i,
  input  logic [CELL_W-1:0] cfg_hdrm_i,
  input  logic [CELL_W-1:0] hpool_used_i,
  input  logic [CELL_W-1:0] hpool_size_i,
  input  logic [CELL_W+3:0] limit_i,
  input  logic [CELL_W-1:0] free_i,
  output region_e           region_o,
  output logic [CELL_W-1:0] add_min_o,
  output logic [CELL_W-1:0] add_shr_o,
  output logic [CELL_W-1:0] add_hdrm_o,
  output logic              set_pause_o,
  output logic              res_err_o,
  output logic              lossy_drop_o
);
  logic [CELL_W-1:0] n_w;
  logic [CELL_W-1:0] room_min;
  logic [CELL_W-1:0] to_min;
  logic [CELL_W-1:0] rest;
  logic [CELL_W-1:0] hd_need;
  logic              shr_fit;
  logic              hd_fit;

  always_comb begin
    n_w      = {{(CELL_W-PKT_W){1'b0}}, cells_i};
    room_min = (cfg_min_i > min_used_i) ? (cfg_min_i - min_used_i) : '0;
    to_min   = lossless_i ? ((n_w < room_min) ? n_w : room_min) : '0;
    rest     = n_w - to_min;
    shr_fit  = (({4'b0000, shr_used_i} + {4'b0000, rest}) <= limit_i) && (rest <= free_i);
    hd_need  = paused_i ? n_w : rest;
    hd_fit   = (({1'b0, hdrm_used_i} + {1'b0, hd_need}) <= {1'b0, cfg_hdrm_i})
            && (({1'b0, hpool_used_i} + {1'b0, hd_need}) <= {1'b0, hpool_size_i});

    region_o     = REG_DROP;
    add_min_o    = '0;
    add_shr_o    = '0;
    add_hdrm_o   = '0;
    set_pause_o  = 1'b0;
    res_err_o    = 1'b0;
    lossy_drop_o = 1'b0;

    if (valid_i) begin
      if (!lossless_i) begin
        if (shr_fit) begin
          add_shr_o = rest;
          region_o  = REG_SHR;
        end else begin
          lossy_drop_o = 1'b1;
        end
      end else if (paused_i) begin
        if (hd_fit) begin
          add_hdrm_o = n_w;
          region_o   = REG_HDRM;
        end else begin
          res_err_o = 1'b1;
        end
      end else if (rest == '0) begin
        add_min_o = to_min;
        region_o  = REG_MIN;
      end else if (shr_fit) begin
        add_min_o = to_min;
        add_shr_o = rest;
        region_o  = REG_SHR;
      end else begin
        set_pause_o = 1'b1;
        if (hd_fit) begin
          add_min_o  = to_min;
          add_hdrm_o = rest;
          region_o   = REG_HDRM;
        end else begin
          res_err_o = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pgc_ingress.sv
module pgc_ingress
  import pgc_pkg::*;
#(
  parameter int NUM_PG  = 8,
  parameter int NUM_PRI = 8,
  parameter int NUM_LL  = 6,
  parameter int CELL_W  = 14,
  parameter int PKT_W   = 6,
  parameter int ERR_W   = 16,
  localparam int PG_W   = $clog2(NUM_PG)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    arr_valid_i,
  input  logic [PG_W-1:0]         arr_pg_i,
  input  logic [PKT_W-1:0]        arr_cells_i,
  input  logic                    rel_valid_i,
  input  logic [PG_W-1:0]         rel_pg_i,
  input  logic [CELL_W-1:0]       rel_cells_i,
  input  logic [NUM_PRI-1:0]      cfg_pfc_en_i,
  input  logic [NUM_PRI*PG_W-1:0] cfg_pri_pg_i,
  input  logic [CELL_W-1:0]       cfg_min_i,
  input  logic [CELL_W-1:0]       cfg_hdrm_i,
  input  logic [CELL_W-1:0]       cfg_hyst_i,
  input  logic [ALPHA_W-1:0]      cfg_ll_alpha_i,
  input  logic [ALPHA_W-1:0]      cfg_ly_alpha_i,
  input  logic [CELL_W-1:0]       cfg_ll_pool_i,
  input  logic [CELL_W-1:0]       cfg_ly_pool_i,
  input  logic [CELL_W-1:0]       cfg_hdrm_pool_i,
  output logic                    dec_valid_o,
  output logic [1:0]              dec_region_o,
  output logic [NUM_PRI-1:0]      pause_o,
  output logic [ERR_W-1:0]        res_err_cnt_o,
  output logic [ERR_W-1:0]        lossy_drop_cnt_o
);
  localparam int LIM_W = CELL_W + 4;
  localparam logic [ERR_W-1:0] ERR_MAX = '1;

  // per-group state
  logic [CELL_W-1:0] min_q  [NUM_PG];
  logic [CELL_W-1:0] shr_q  [NUM_PG];
  logic [CELL_W-1:0] hdrm_q [NUM_PG];
  logic [NUM_PG-1:0] paused_q;
  logic [CELL_W-1:0] min_mid  [NUM_PG];
  logic [CELL_W-1:0] shr_mid  [NUM_PG];
  logic [CELL_W-1:0] hdrm_mid [NUM_PG];
  logic [NUM_PG-1:0] paused_mid;
  logic [CELL_W-1:0] min_nxt  [NUM_PG];
  logic [CELL_W-1:0] shr_nxt  [NUM_PG];
  logic [CELL_W-1:0] hdrm_nxt [NUM_PG];
  logic [NUM_PG-1:0] paused_nxt;

  // pool state: index 0 lossless, 1 lossy
  logic [CELL_W-1:0] pool_used_q   [NUM_POOLS];
  logic [CELL_W-1:0] pool_used_mid [NUM_POOLS];
  logic [CELL_W-1:0] pool_used_nxt [NUM_POOLS];
  logic [CELL_W-1:0] pool_size     [NUM_POOLS];
  logic [ALPHA_W-1:0] pool_alpha   [NUM_POOLS];
  logic [CELL_W-1:0] pool_free     [NUM_POOLS];
  logic [LIM_W-1:0]  pool_limit    [NUM_POOLS];
  logic [CELL_W-1:0] hp_used_q;
  logic [CELL_W-1:0] hp_used_mid;
  logic [CELL_W-1:0] hp_used_nxt;

  logic              dec_valid_q;
  logic [1:0]        dec_region_q;
  logic [ERR_W-1:0]  err_q;
  logic [ERR_W-1:0]  ldrop_q;

  logic              st_en;
  logic              rel_ll;
  logic              arr_ll;
  logic [CELL_W-1:0] sub_hdrm;
  logic [CELL_W-1:0] sub_shr;
  logic [CELL_W-1:0] sub_min;
  region_e           adm_region;
  logic [CELL_W-1:0] add_min;
  logic [CELL_W-1:0] add_shr;
  logic [CELL_W-1:0] add_hdrm;
  logic              set_pause;
  logic              res_err;
  logic              lossy_drop;

  assign rel_ll = int'(rel_pg_i) < NUM_LL;
  assign arr_ll = int'(arr_pg_i) < NUM_LL;
  assign st_en  = arr_valid_i | rel_valid_i;

  assign pool_size[0]  = cfg_ll_pool_i;
  assign pool_size[1]  = cfg_ly_pool_i;
  assign pool_alpha[0] = cfg_ll_alpha_i;
  assign pool_alpha[1] = cfg_ly_alpha_i;

  // release stage: headroom, then shared, then minimum
  pgc_release #(.CELL_W(CELL_W)) u_rel (
    .cells_i    (rel_cells_i),
    .hdrm_i     (hdrm_q[rel_pg_i]),
    .shr_i      (shr_q[rel_pg_i]),
    .min_i      (min_q[rel_pg_i]),
    .sub_hdrm_o (sub_hdrm),
    .sub_shr_o  (sub_shr),
    .sub_min_o  (sub_min)
  );

  always_comb begin
    for (int g = 0; g < NUM_PG; g++) begin
      min_mid[g]  = min_q[g];
      shr_mid[g]  = shr_q[g];
      hdrm_mid[g] = hdrm_q[g];
      if (rel_valid_i && (rel_pg_i == PG_W'(g))) begin
        min_mid[g]  = min_q[g] - sub_min;
        shr_mid[g]  = shr_q[g] - sub_shr;
        hdrm_mid[g] = hdrm_q[g] - sub_hdrm;
      end
    end
    pool_used_mid[0] = pool_used_q[0] - ((rel_valid_i && rel_ll) ? sub_shr : '0);
    pool_used_mid[1] = pool_used_q[1] - ((rel_valid_i && !rel_ll) ? sub_shr : '0);
    hp_used_mid      = hp_used_q - (rel_valid_i ? sub_hdrm : '0);
  end

  // dynamic thresholds, one per service pool, on post-release occupancy
  for (genvar p = 0; p < NUM_POOLS; p++) begin : g_pool
    pgc_thresh #(.CELL_W(CELL_W)) u_thr (
      .pool_size_i (pool_size[p]),
      .pool_used_i (pool_used_mid[p]),
      .alpha_i     (pool_alpha[p]),
      .free_o      (pool_free[p]),
      .limit_o     (pool_limit[p])
    );
  end

  // resume check happens only on a release to a paused lossless group
  always_comb begin
    paused_mid = paused_q;
    for (int g = 0; g < NUM_LL; g++) begin
      if (rel_valid_i && (rel_pg_i == PG_W'(g)) && paused_q[g] &&
          (({4'b0000, shr_mid[g]} + {4'b0000, cfg_hyst_i}) < pool_limit[0])) begin
        paused_mid[g] = 1'b0;
      end
    end
  end

  pgc_admit #(.CELL_W(CELL_W), .PKT_W(PKT_W)) u_adm (
    .valid_i      (arr_valid_i),
    .lossless_i   (arr_ll),
    .paused_i     (paused_mid[arr_pg_i]),
    .cells_i      (arr_cells_i),
    .min_used_i   (min_mid[arr_pg_i]),
    .shr_used_i   (shr_mid[arr_pg_i]),
    .hdrm_used_i  (hdrm_mid[arr_pg_i]),
    .cfg_min_i    (cfg_min_i),
    .cfg_hdrm_i   (cfg_hdrm_i),
    .hpool_used_i (hp_used_mid),
    .hpool_size_i (cfg_hdrm_pool_i),
    .limit_i      (arr_ll ? pool_limit[0] : pool_limit[1]),
    .free_i       (arr_ll ? pool_free[0] : pool_free[1]),
    .region_o     (adm_region),
    .add_min_o    (add_min),
    .add_shr_o    (add_shr),
    .add_hdrm_o   (add_hdrm),
    .set_pause_o  (set_pause),
    .res_err_o    (res_err),
    .lossy_drop_o (lossy_drop)
  );

  always_comb begin
    for (int g = 0; g < NUM_PG; g++) begin
      min_nxt[g]    = min_mid[g];
      shr_nxt[g]    = shr_mid[g];
      hdrm_nxt[g]   = hdrm_mid[g];
      paused_nxt[g] = paused_mid[g];
      if (arr_valid_i && (arr_pg_i == PG_W'(g))) begin
        min_nxt[g]    = min_mid[g] + add_min;
        shr_nxt[g]    = shr_mid[g] + add_shr;
        hdrm_nxt[g]   = hdrm_mid[g] + add_hdrm;
        paused_nxt[g] = paused_mid[g] | set_pause;
      end
    end
    pool_used_nxt[0] = pool_used_mid[0] + (arr_ll ? add_shr : '0);
    pool_used_nxt[1] = pool_used_mid[1] + (arr_ll ? '0 : add_shr);
    hp_used_nxt      = hp_used_mid + add_hdrm;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int g = 0; g < NUM_PG; g++) begin
        min_q[g]  <= '0;
        shr_q[g]  <= '0;
        hdrm_q[g] <= '0;
      end
      paused_q <= '0;
      for (int p = 0; p < NUM_POOLS; p++) begin
        pool_used_q[p] <= '0;
      end
      hp_used_q <= '0;
    end else if (st_en) begin
      for (int g = 0; g < NUM_PG; g++) begin
        min_q[g]  <= min_nxt[g];
        shr_q[g]  <= shr_nxt[g];
        hdrm_q[g] <= hdrm_nxt[g];
      end
      paused_q <= paused_nxt;
      for (int p = 0; p < NUM_POOLS; p++) begin
        pool_used_q[p] <= pool_used_nxt[p];
      end
      hp_used_q <= hp_used_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_valid_q  <= 1'b0;
      dec_region_q <= 2'd0;
      err_q        <= '0;
      ldrop_q      <= '0;
    end else begin
      dec_valid_q  <= arr_valid_i;
      dec_region_q <= arr_valid_i ? adm_region : REG_DROP;
      if (res_err && (err_q != ERR_MAX)) begin
        err_q <= err_q + 1'b1;
      end
      if (lossy_drop && (ldrop_q != ERR_MAX)) begin
        ldrop_q <= ldrop_q + 1'b1;
      end
    end
  end

  for (genvar p = 0; p < NUM_PRI; p++) begin : g_pause
    assign pause_o[p] = cfg_pfc_en_i[p] & paused_q[cfg_pri_pg_i[p*PG_W +: PG_W]];
  end

  assign dec_valid_o      = dec_valid_q;
  assign dec_region_o     = dec_region_q;
  assign res_err_cnt_o    = err_q;
  assign lossy_drop_cnt_o = ldrop_q;
endmodule

// File: rtl/pgc_ingress_chk.sv
module pgc_ingress_chk
  import pgc_pkg::*;
#(
  parameter int NUM_PG  = 8,
  parameter int NUM_PRI = 8,
  parameter int NUM_LL  = 6,
  parameter int CELL_W  = 14,
  parameter int ERR_W   = 16,
  localparam int PG_W   = $clog2(NUM_PG)
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    arr_valid_i,
  input logic [PG_W-1:0]         arr_pg_i,
  input logic                    rel_valid_i,
  input logic [NUM_PRI-1:0]      cfg_pfc_en_i,
  input logic [NUM_PRI*PG_W-1:0] cfg_pri_pg_i,
  input logic [CELL_W-1:0]       cfg_hdrm_pool_i,
  input logic                    dec_valid_o,
  input logic [1:0]              dec_region_o,
  input logic [NUM_PRI-1:0]      pause_o,
  input logic [ERR_W-1:0]        res_err_cnt_o,
  input logic [ERR_W-1:0]        lossy_drop_cnt_o,
  input logic [CELL_W-1:0]       hp_used_q
);
  AST_DEC_AFTER_ARR: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid_o |-> $past(arr_valid_i)); // R10

  AST_LOSSY_REGION: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid_o && (int'($past(arr_pg_i)) >= NUM_LL)) |->
      (dec_region_o == REG_SHR || dec_region_o == REG_DROP)); // R6

  AST_ERR_ON_LL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (res_err_cnt_o != $past(res_err_cnt_o)) |->
      (dec_valid_o && dec_region_o == REG_DROP && (int'($past(arr_pg_i)) < NUM_LL))); // R5

  AST_LDROP_ON_LY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (lossy_drop_cnt_o != $past(lossy_drop_cnt_o)) |->
      (dec_valid_o && dec_region_o == REG_DROP && (int'($past(arr_pg_i)) >= NUM_LL))); // R6

  AST_PAUSE_RISE_HDRM: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(pause_o & ~$past(pause_o))) && $stable(cfg_pfc_en_i) && $stable(cfg_pri_pg_i)) |->
      (dec_valid_o && (dec_region_o == REG_HDRM || dec_region_o == REG_DROP))); // R4

  AST_PAUSE_FALL_REL: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(~pause_o & $past(pause_o))) && $stable(cfg_pfc_en_i) && $stable(cfg_pri_pg_i)) |->
      $past(rel_valid_i)); // R9

  AST_HDRM_POOL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    hp_used_q <= cfg_hdrm_pool_i); // R5
endmodule

bind pgc_ingress pgc_ingress_chk #(
  .NUM_PG(NUM_PG), .NUM_PRI(NUM_PRI), .NUM_LL(NUM_LL), .CELL_W(CELL_W), .ERR_W(ERR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .arr_valid_i(arr_valid_i), .arr_pg_i(arr_pg_i),
  .rel_valid_i(rel_valid_i), .cfg_pfc_en_i(cfg_pfc_en_i), .cfg_pri_pg_i(cfg_pri_pg_i),
  .cfg_hdrm_pool_i(cfg_hdrm_pool_i), .dec_valid_o(dec_valid_o), .dec_region_o(dec_region_o),
  .pause_o(pause_o), .res_err_cnt_o(res_err_cnt_o), .lossy_drop_cnt_o(lossy_drop_cnt_o),
  .hp_used_q(hp_used_q)
);

// File: tb/sim_pgc_ingress.sv
module sim_pgc_ingress;
  localparam int CLK_PERIOD = 10;
  localparam int ERRW = 3;
  localparam int SAT = (1 << ERRW) - 1;

  logic        clk;
  logic        rst_n;
  logic        arr_valid;
  logic [2:0]  arr_pg;
  logic [5:0]  arr_cells;
  logic        rel_valid;
  logic [2:0]  rel_pg;
  logic [13:0] rel_cells;
  logic [7:0]  pfc_en;
  logic [23:0] pri_pg;
  logic [13:0] c_min, c_hdrm, c_hyst, c_llp, c_lyp, c_hpp;
  logic [3:0]  c_lla, c_lya;
  logic        dec_valid;
  logic [1:0]  dec_region;
  logic [7:0]  pause;
  logic [ERRW-1:0] err_cnt, ldrop_cnt;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  int mmin[8], mshr[8], mhd[8];
  bit mx[8];
  int mll, mly, mhp, merr, mld;
  int pmap[8];

  pgc_ingress #(.ERR_W(ERRW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .arr_valid_i(arr_valid), .arr_pg_i(arr_pg), .arr_cells_i(arr_cells),
    .rel_valid_i(rel_valid), .rel_pg_i(rel_pg), .rel_cells_i(rel_cells),
    .cfg_pfc_en_i(pfc_en), .cfg_pri_pg_i(pri_pg),
    .cfg_min_i(c_min), .cfg_hdrm_i(c_hdrm), .cfg_hyst_i(c_hyst),
    .cfg_ll_alpha_i(c_lla), .cfg_ly_alpha_i(c_lya),
    .cfg_ll_pool_i(c_llp), .cfg_ly_pool_i(c_lyp), .cfg_hdrm_pool_i(c_hpp),
    .dec_valid_o(dec_valid), .dec_region_o(dec_region), .pause_o(pause),
    .res_err_cnt_o(err_cnt), .lossy_drop_cnt_o(ldrop_cnt)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int lim(input int size, input int used, input int code);
    int f;
    int k;
    f = (size > used) ? size - used : 0;
    k = (code > 10) ? 10 : code;
    return (k >= 7) ? (f << (k - 7)) : (f >> (7 - k));
  endfunction

  function automatic int minf(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  function automatic int exp_pause();
    int v = 0;
    for (int p = 0; p < 8; p++) if (pfc_en[p] && mx[pmap[p]]) v |= (1 << p);
    return v;
  endfunction

  task automatic do_reset(input int lla, input int lya, input int cmin);
    rst_n = 1'b0;
    arr_valid = 0; rel_valid = 0; arr_pg = 0; arr_cells = 0; rel_pg = 0; rel_cells = 0;
    c_min = 14'(cmin); c_hdrm = 14'd6; c_hyst = 14'd2;
    c_lla = 4'(lla); c_lya = 4'(lya);
    c_llp = 14'd40; c_lyp = 14'd24; c_hpp = 14'd10;
    for (int p = 0; p < 8; p++) pri_pg[p*3 +: 3] = 3'(pmap[p]);
    for (int g = 0; g < 8; g++) begin mmin[g] = 0; mshr[g] = 0; mhd[g] = 0; mx[g] = 0; end
    mll = 0; mly = 0; mhp = 0; merr = 0; mld = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic step(input bit av, input int pg, input int n,
                      input bit rv, input int rpg, input int rc, input string tag);
    int reg_e;
    int h, s, m, c1, c2, f, L, room, tm, rest;
    arr_valid = av; arr_pg = 3'(pg); arr_cells = 6'(n);
    rel_valid = rv; rel_pg = 3'(rpg); rel_cells = 14'(rc);
    if (rv) begin
      h = minf(rc, mhd[rpg]); c1 = rc - h;
      s = minf(c1, mshr[rpg]); c2 = c1 - s;
      m = minf(c2, mmin[rpg]);
      mhd[rpg] -= h; mshr[rpg] -= s; mmin[rpg] -= m; mhp -= h;
      if (rpg < 6) mll -= s; else mly -= s;
      if (rpg < 6 && mx[rpg] && (mshr[rpg] + int'(c_hyst) < lim(int'(c_llp), mll, int'(c_lla))))
        mx[rpg] = 0;
    end
    reg_e = 0;
    if (av) begin
      if (pg >= 6) begin
        f = (int'(c_lyp) > mly) ? int'(c_lyp) - mly : 0;
        if (mshr[pg] + n <= lim(int'(c_lyp), mly, int'(c_lya)) && n <= f) begin
          mshr[pg] += n; mly += n; reg_e = 2;
        end else if (mld < SAT) mld++;
      end else begin
        f = (int'(c_llp) > mll) ? int'(c_llp) - mll : 0;
        L = lim(int'(c_llp), mll, int'(c_lla));
        room = (int'(c_min) > mmin[pg]) ? int'(c_min) - mmin[pg] : 0;
        tm = minf(n, room); rest = n - tm;
        if (mx[pg]) begin
          if (mhd[pg] + n <= int'(c_hdrm) && mhp + n <= int'(c_hpp)) begin
            mhd[pg] += n; mhp += n; reg_e = 3;
          end else if (merr < SAT) merr++;
        end else if (rest == 0) begin
          mmin[pg] += tm; reg_e = 1;
        end else if (mshr[pg] + rest <= L && rest <= f) begin
          mmin[pg] += tm; mshr[pg] += rest; mll += rest; reg_e = 2;
        end else begin
          mx[pg] = 1;
          if (mhd[pg] + rest <= int'(c_hdrm) && mhp + rest <= int'(c_hpp)) begin
            mmin[pg] += tm; mhd[pg] += rest; mhp += rest; reg_e = 3;
          end else if (merr < SAT) merr++;
        end
      end
    end
    @(posedge clk);
    @(negedge clk);
    arr_valid = 0; rel_valid = 0;
    chk(dec_valid == av, {"R10 valid ", tag}, int'(dec_valid), int'(av));
    if (av) chk(int'(dec_region) == reg_e, {"region ", tag}, int'(dec_region), reg_e);
    chk(int'(pause) == exp_pause(), {"R7 pause ", tag}, int'(pause), exp_pause());
    chk(int'(err_cnt) == merr, {"R5 err ", tag}, int'(err_cnt), merr);
    chk(int'(ldrop_cnt) == mld, {"R6 ldrop ", tag}, int'(ldrop_cnt), mld);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    pmap = '{0, 6, 7, 3, 4, 6, 7, 1};
    pfc_en = 8'b1001_1011;
    do_reset(7, 10, 4);
    // R1: reset state
    chk(dec_valid == 0, "R1 valid", int'(dec_valid), 0);
    chk(pause == 0, "R1 pause", int'(pause), 0);
    chk(err_cnt == 0 && ldrop_cnt == 0, "R1 counters", int'(err_cnt) + int'(ldrop_cnt), 0);

    // R2: minimum, then spill to shared
    step(1, 0, 3, 0, 0, 0, "R2");
    step(1, 0, 3, 0, 0, 0, "R2");
    // R4 / R5: shared overflow, pause, headroom then drops
    for (int i = 0; i < 6; i++) step(1, 0, (i < 3) ? 8 : 5, 0, 0, 0, "R4");
    // second group hits the headroom pool bound
    step(1, 3, 4, 0, 0, 0, "R2");
    step(1, 3, 20, 0, 0, 0, "R3");
    step(1, 3, 3, 0, 0, 0, "R4");
    step(1, 3, 3, 0, 0, 0, "R5");
    step(0, 0, 0, 0, 0, 0, "R10");
    // R9 / R8: releases drain headroom first, resume with margin
    for (int i = 0; i < 6; i++) step(0, 0, 0, 1, 0, 4, "R9");
    step(1, 0, 2, 0, 0, 0, "R8");
    // R6: lossy groups
    for (int i = 0; i < 4; i++) step(1, 6, 10, 0, 0, 0, "R6");
    step(1, 7, 4, 0, 0, 0, "R6");
    step(1, 7, 1, 0, 0, 0, "R6");
    // R8: oversized release clamps, everything returned
    step(0, 0, 0, 1, 3, 100, "R8");
    step(1, 3, 4, 0, 0, 0, "R8");
    step(1, 3, 1, 0, 0, 0, "R8");
    // R11: release and arrival together
    step(1, 0, 5, 1, 0, 3, "R11");
    step(1, 6, 9, 1, 6, 20, "R11");
    // R10: lossy drop counter saturation
    for (int i = 0; i < 10; i++) step(1, 7, 40, 0, 0, 0, "R10");

    // R3: every alpha code, both pools
    for (int k = 0; k < 12; k++) begin
      int L;
      do_reset(7, k, 4);
      L = lim(24, 0, k);
      step(1, 6, minf(L + 1, 63), 0, 0, 0, "R3");
      step(1, 7, (L < 1) ? 1 : minf(L, 63), 0, 0, 0, "R3");
      do_reset(k, 10, 0);
      L = lim(40, 0, k);
      step(1, 1, (L < 1) ? 1 : minf(L, 63), 0, 0, 0, "R3");
      step(1, 2, minf(L + 1, 63), 0, 0, 0, "R3");
      step(1, 7, 3, 0, 0, 0, "R3");
    end

    // R5: resource error saturation via repeated headroom overflow
    do_reset(7, 10, 0);
    step(1, 0, 40, 0, 0, 0, "R4");
    for (int i = 0; i < 10; i++) step(1, 0, 7, 0, 0, 0, "R5");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule